// File: doc/BRIEF.md
# Banked Control Register File

This block holds the control state of a small 32-bit processor: an 8-bit status byte with a companion backup byte, a separate condition flag, a second-level backup status byte, two stack-pointer banks (interrupt and user), two backup program counters and two plain scratch words. Software reaches all of it through a combinational read port and a clocked write port, both indexed by a control-register number.

The active stack pointer is not kept here. It lives in general-purpose register r15, which sits outside the block. The block reaches r15 through a side channel: it samples the current r15 value, and it can request a one-cycle write of a new value into it. Bit 7 of the status byte selects the stack. When that bit is 1 the user stack is active, and when it is 0 the interrupt stack is active. When a status write flips this bit, the outgoing pointer is saved into its bank and the incoming bank is loaded into r15. A read or write of the stack-pointer register for the stack that is currently active goes to r15 instead of to the bank.

Top module: `crf_banked`

## Requirements
- R1: Reading index 0 returns 16 zero bits in 31:16, then the backup status byte masked with 0xC1 in 15:8, then the status byte masked with 0xC0 in 7:0 with the condition flag placed in bit 0.
- R2: Writing index 0 loads wr_data[7:0] into the status byte and wr_data[15:8] into the backup status byte, and sets the condition flag from wr_data[0]. The flag and status bit 7 (user_stack_o) are visible from the next cycle.
- R3: A status write that changes bit 7 from 1 to 0 stores the current r15 into the user bank and writes the old interrupt bank value to r15, in the same clock edge.
- R4: A status write that changes bit 7 from 0 to 1 stores the current r15 into the interrupt bank and writes the old user bank value to r15, in the same clock edge.
- R5: While bit 7 is 0, index 2 (interrupt SP) reads and writes r15. While bit 7 is 1, index 3 (user SP) reads and writes r15. Otherwise these indices use their banks. No r15 write is requested in any other case.
- R6: Indices 6 and 7 (backup PC and second backup PC) store all 32 written bits and read back with bit 0 forced to 0.
- R7: Index 8 (second backup status) stores wr_data[7:0] and reads back as that byte masked with 0xC1, zero-extended.
- R8: Index 1 reads the condition flag zero-extended to 32 bits. Writing index 1 changes only the flag, taking it from wr_data[0].
- R9: Indices 4 and 5 are plain 32-bit storage that read back exactly what was written.
- R10: Indices 9 to 15 read as zero. Writes to them change no register and request no r15 write.
- R11: After reset every register reads as zero, and the interrupt stack is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_idx | input | IDX_W | Read index |
| rd_data | output | 32 | Combinational read data |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | IDX_W | Write index |
| wr_data | input | 32 | Write data |
| sp_in | input | 32 | Current value of r15 |
| sp_wr_en | output | 1 | Request to write r15 at this clock edge |
| sp_wr_data | output | 32 | Value to write into r15 |
| cond_o | output | 1 | Condition flag |
| user_stack_o | output | 1 | Status bit 7: 1 means the user stack is active |

## Verification
The bench sweeps every index with several data words. After each write it reads back all sixteen indices and compares r15 against an arithmetic model. The patterns alternate status bit 7, so that both swap directions and both redirection states occur with different r15 contents. This separates a missing or reversed swap from an error in the masking alone. Words with bit 0 set and words with all bits set show whether a read mask is applied, and whether a write to the flag or to an unmapped index touches any other register.

// File: rtl/crf_pkg.sv
package crf_pkg;
    localparam int XLEN      = 32;
    localparam int BYTE_W    = 8;
    localparam int NUM_AUX   = 2;
    localparam int AUX_BASE  = 4;

    localparam int CR_STS    = 0;
    localparam int CR_COND   = 1;
    localparam int CR_ISP    = 2;
    localparam int CR_USP    = 3;
    localparam int CR_BPC    = 6;
    localparam int CR_BBPC   = 7;
    localparam int CR_BBSTS  = 8;

    localparam int SMODE_BIT = 7;
    localparam logic [BYTE_W-1:0] STS_MASK  = 8'hC0;
    localparam logic [BYTE_W-1:0] BSTS_MASK = 8'hC1;

    typedef struct packed {
        logic [BYTE_W-1:0]             sts;
        logic [BYTE_W-1:0]             bsts;
        logic                          cond;
        logic [BYTE_W-1:0]             bbsts;
        logic [XLEN-1:0]               isp;
        logic [XLEN-1:0]               usp;
        logic [XLEN-1:0]               bpc;
        logic [XLEN-1:0]               bbpc;
        logic [NUM_AUX-1:0][XLEN-1:0]  aux;
    } crf_state_t;
endpackage

// File: rtl/crf_next.sv
module crf_next
    import crf_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  crf_state_t        state_q,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [XLEN-1:0]   wr_data,
    input  logic [XLEN-1:0]   sp_in,
    output crf_state_t        state_d,
    output logic              sp_wr_en,
    output logic [XLEN-1:0]   sp_wr_data
);
    logic old_user;
    logic new_user;

    assign old_user = state_q.sts[SMODE_BIT];
    assign new_user = wr_data[SMODE_BIT];

    always_comb begin
        state_d    = state_q;
        sp_wr_en   = 1'b0;
        sp_wr_data = '0;
        if (wr_en) begin
            if (wr_idx == IDX_W'(CR_STS)) begin
                state_d.sts  = wr_data[BYTE_W-1:0];
                state_d.bsts = wr_data[2*BYTE_W-1:BYTE_W];
                state_d.cond = wr_data[0];
                if (old_user && !new_user) begin
                    state_d.usp = sp_in;
                    sp_wr_en    = 1'b1;
                    sp_wr_data  = state_q.isp;
                end else if (!old_user && new_user) begin
                    state_d.isp = sp_in;
                    sp_wr_en    = 1'b1;
                    sp_wr_data  = state_q.usp;
                end
            end else if (wr_idx == IDX_W'(CR_COND)) begin
                state_d.cond = wr_data[0];
            end else if (wr_idx == IDX_W'(CR_ISP)) begin
                if (!old_user) begin
                    sp_wr_en   = 1'b1;
                    sp_wr_data = wr_data;
                end else begin
                    state_d.isp = wr_data;
                end
            end else if (wr_idx == IDX_W'(CR_USP)) begin
                if (old_user) begin
                    sp_wr_en   = 1'b1;
                    sp_wr_data = wr_data;
                end else begin
                    state_d.usp = wr_data;
                end
            end else if (wr_idx == IDX_W'(CR_BPC)) begin
                state_d.bpc = wr_data;
            end else if (wr_idx == IDX_W'(CR_BBPC)) begin
                state_d.bbpc = wr_data;
            end else if (wr_idx == IDX_W'(CR_BBSTS)) begin
                state_d.bbsts = wr_data[BYTE_W-1:0];
            end else begin
                for (int k = 0; k < NUM_AUX; k++) begin
                    if (wr_idx == IDX_W'(AUX_BASE + k)) begin
                        state_d.aux[k] = wr_data;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/crf_rdmux.sv
module crf_rdmux
    import crf_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  crf_state_t        state_q,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [XLEN-1:0]   sp_in,
    output logic [XLEN-1:0]   rd_data
);
    localparam int HI_PAD = XLEN - 2*BYTE_W;
    localparam int BY_PAD = XLEN - BYTE_W;

    logic            user_act;
    logic [XLEN-1:0] aux_rd;
    logic            aux_hit;

    assign user_act = state_q.sts[SMODE_BIT];

    always_comb begin
        aux_rd  = '0;
        aux_hit = 1'b0;
        for (int k = 0; k < NUM_AUX; k++) begin
            if (rd_idx == IDX_W'(AUX_BASE + k)) begin
                aux_rd  = state_q.aux[k];
                aux_hit = 1'b1;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_idx == IDX_W'(CR_STS)) begin
            rd_data = {{HI_PAD{1'b0}}, state_q.bsts & BSTS_MASK,
                       (state_q.sts & STS_MASK) | {{(BYTE_W-1){1'b0}}, state_q.cond}};
        end else if (rd_idx == IDX_W'(CR_COND)) begin
            rd_data = {{(XLEN-1){1'b0}}, state_q.cond};
        end else if (rd_idx == IDX_W'(CR_ISP)) begin
            rd_data = user_act ? state_q.isp : sp_in;
        end else if (rd_idx == IDX_W'(CR_USP)) begin
            rd_data = user_act ? sp_in : state_q.usp;
        end else if (rd_idx == IDX_W'(CR_BPC)) begin
            rd_data = {state_q.bpc[XLEN-1:1], 1'b0};
        end else if (rd_idx == IDX_W'(CR_BBPC)) begin
            rd_data = {state_q.bbpc[XLEN-1:1], 1'b0};
        end else if (rd_idx == IDX_W'(CR_BBSTS)) begin
            rd_data = {{BY_PAD{1'b0}}, state_q.bbsts & BSTS_MASK};
        end else if (aux_hit) begin
            rd_data = aux_rd;
        end
    end
endmodule

// File: rtl/crf_banked.sv
module crf_banked
    import crf_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [XLEN-1:0]   rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [XLEN-1:0]   wr_data,
    input  logic [XLEN-1:0]   sp_in,
    output logic              sp_wr_en,
    output logic [XLEN-1:0]   sp_wr_data,
    output logic              cond_o,
    output logic              user_stack_o
);
    crf_state_t state_d;
    crf_state_t state_q;

    crf_next #(.IDX_W(IDX_W)) u_next (
        .state_q   (state_q),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .sp_in     (sp_in),
        .state_d   (state_d),
        .sp_wr_en  (sp_wr_en),
        .sp_wr_data(sp_wr_data)
    );

    crf_rdmux #(.IDX_W(IDX_W)) u_rdmux (
        .state_q(state_q),
        .rd_idx (rd_idx),
        .sp_in  (sp_in),
        .rd_data(rd_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cond_o       = state_q.cond;
    assign user_stack_o = state_q.sts[SMODE_BIT];
endmodule

// File: rtl/crf_banked_chk.sv
module crf_banked_chk
    import crf_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [IDX_W-1:0]  rd_idx,
    input logic [XLEN-1:0]   rd_data,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [XLEN-1:0]   wr_data,
    input logic              sp_wr_en,
    input logic              cond_o,
    input logic              user_stack_o
);
    AST_STS_READ_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_idx == IDX_W'(CR_STS) |-> (rd_data[31:16] == '0 && rd_data[13:9] == '0 && rd_data[5:1] == '0)); // R1

    AST_MODE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IDX_W'(CR_STS)) |=> user_stack_o == $past(wr_data[SMODE_BIT])); // R2

    AST_SWAP_ON_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IDX_W'(CR_STS) && wr_data[SMODE_BIT] != user_stack_o) |-> sp_wr_en); // R3

    AST_SP_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> !sp_wr_en); // R5

    AST_BPC_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx == IDX_W'(CR_BPC) || rd_idx == IDX_W'(CR_BBPC)) |-> !rd_data[0]); // R6

    AST_COND_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IDX_W'(CR_COND)) |=> cond_o == $past(wr_data[0])); // R8

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_idx > IDX_W'(CR_BBSTS) |-> rd_data == '0); // R10

    AST_UNMAPPED_NO_SP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx > IDX_W'(CR_BBSTS)) |-> !sp_wr_en); // R10
endmodule

bind crf_banked crf_banked_chk #(.IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_idx      (rd_idx),
    .rd_data     (rd_data),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_data     (wr_data),
    .sp_wr_en    (sp_wr_en),
    .cond_o      (cond_o),
    .user_stack_o(user_stack_o)
);

// File: tb/crf_banked_tb.sv
`timescale 1ns/1ps
module crf_banked_tb;
    localparam int IDX_W = 4;
    localparam int NIDX  = 1 << IDX_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [IDX_W-1:0]  rd_idx = '0;
    logic [31:0]       rd_data;
    logic              wr_en = 1'b0;
    logic [IDX_W-1:0]  wr_idx = '0;
    logic [31:0]       wr_data = '0;
    logic [31:0]       r15 = 32'h0000_F000;
    logic              sp_wr_en;
    logic [31:0]       sp_wr_data;
    logic              cond_o;
    logic              user_stack_o;
    logic              cpu_we = 1'b0;
    logic [31:0]       cpu_val = '0;

    int checks = 0;
    int errors = 0;

    logic [7:0]  m_sts = '0, m_bsts = '0, m_bbsts = '0;
    logic        m_cond = 1'b0;
    logic [31:0] m_isp = '0, m_usp = '0, m_bpc = '0, m_bbpc = '0, m_a4 = '0, m_a5 = '0;
    logic [31:0] m_r15 = 32'h0000_F000;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (sp_wr_en)    r15 <= sp_wr_data;
        else if (cpu_we) r15 <= cpu_val;
    end

    crf_banked #(.IDX_W(IDX_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_data(rd_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .sp_in(r15),
        .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data),
        .cond_o(cond_o), .user_stack_o(user_stack_o)
    );

    function automatic logic [31:0] exp_rd(input int i);
        case (i)
            0: return {16'h0, m_bsts & 8'hC1, (m_sts & 8'hC0) | {7'h0, m_cond}};
            1: return {31'h0, m_cond};
            2: return m_sts[7] ? m_isp : m_r15;
            3: return m_sts[7] ? m_r15 : m_usp;
            4: return m_a4;
            5: return m_a5;
            6: return {m_bpc[31:1], 1'b0};
            7: return {m_bbpc[31:1], 1'b0};
            8: return {24'h0, m_bbsts & 8'hC1};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string req_of(input int i);
        case (i)
            0: return "R1";
            1: return "R8";
            2, 3: return "R5";
            4, 5: return "R9";
            6, 7: return "R6";
            8: return "R7";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic read_all(input string ctx);
        for (int i = 0; i < NIDX; i++) begin
            @(negedge clk);
            rd_idx = IDX_W'(i);
            #1;
            check($sformatf("%s after %s idx %0d", req_of(i), ctx, i), rd_data, exp_rd(i));
        end
        check($sformatf("R5 r15 after %s", ctx), r15, m_r15);
        check($sformatf("R2 flag after %s", ctx), {30'h0, user_stack_o, cond_o}, {30'h0, m_sts[7], m_cond});
    endtask

    task automatic model_wr(input int i, input logic [31:0] d);
        case (i)
            0: begin
                if (m_sts[7] && !d[7]) begin m_usp = m_r15; m_r15 = m_isp; end
                else if (!m_sts[7] && d[7]) begin m_isp = m_r15; m_r15 = m_usp; end
                m_sts = d[7:0]; m_bsts = d[15:8]; m_cond = d[0];
            end
            1: m_cond = d[0];
            2: if (!m_sts[7]) m_r15 = d; else m_isp = d;
            3: if (m_sts[7]) m_r15 = d; else m_usp = d;
            4: m_a4 = d;
            5: m_a5 = d;
            6: m_bpc = d;
            7: m_bbpc = d;
            8: m_bbsts = d[7:0];
            default: ;
        endcase
    endtask

    task automatic do_wr(input int i, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IDX_W'(i); wr_data = d;
        model_wr(i, d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_r15(input logic [31:0] v);
        @(negedge clk);
        cpu_we = 1'b1; cpu_val = v; m_r15 = v;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] pats [4];
        pats[0] = 32'hA5A5_5AC1;
        pats[1] = 32'hFFFF_FFFF;
        pats[2] = 32'h1234_5601;
        pats[3] = 32'h8000_0080;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        read_all("reset R11");

        // R3 / R4: explicit swaps with distinct r15 contents
        set_r15(32'h1111_0000);
        do_wr(0, 32'h0000_0080);
        read_all("swap to user R4");
        set_r15(32'h2222_0000);
        do_wr(0, 32'h0000_0000);
        read_all("swap to interrupt R3");
        do_wr(0, 32'h0000_0000);
        read_all("status write without flip R2");

        for (int p = 0; p < 4; p++) begin
            for (int i = 0; i < NIDX; i++) begin
                logic [31:0] d;
                d = pats[p] ^ (32'h0101_0100 * i);
                if (i == 0) d[7] = ~m_sts[7];
                do_wr(i, d);
                read_all($sformatf("write idx %0d pat %0d", i, p));
                if (i == 3) set_r15(32'hC0DE_0000 + p);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule